// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a watchdog timer behind a small 32-bit register port. Software programs it through a control word and watches it through a read-only status word. The control word is guarded: a write lands only if the write just before it carried the first key and it carries the second key itself. Any other bus access between the two writes drops the unlock. Each start, stop or keep-alive has to pass through this two-write handshake again. A stray store therefore cannot disarm the timer or stretch its timeout.

Once enabled, a prescaler divides the input clock by one of four ratios. Each divided step takes one off a 16-bit count loaded from the reload field. A pre-warning level rises when the remaining count falls to a chosen fraction of the full 16-bit period. When the count runs out, a one-cycle reset request goes to the system reset logic and the timer halts until software programs it again.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset the control word and the status word both read 0, and prewarn_o and rst_req_o are low.
- R2: The control word (address 0x0) has these fields: bit 31 enable, bits 27:26 pre-warning select, bits 25:24 divider select, bits 23:16 key, bits 15:0 reload. A write to it is applied only when it has key 0xDC and comes straight after a control write with key 0xBE. The readback shows the stored fields, and the key field always reads 0.
- R3: The handshake fails and the write is ignored when the first write lacks 0xBE, when the second write lacks 0xDC, or when any read or write comes between the two writes. A failed handshake returns to the locked state, so a lone 0xDC write is also ignored.
- R4: An applied write with enable set loads the count from the reload field in that cycle. The status word (address 0x8) shows the running state in bit 31 and the count in bits 15:0, with all other bits 0.
- R5: Divider selects 0, 1, 2 and 3 take 1, 64, 4096 and 262144 clock cycles for each count-down step. The first step comes one full divider period after the load.
- R6: While the timer runs, prewarn_o is high whenever the count is at or below 65536 >> (select + 1), that is 32768, 16384, 8192 or 4096 for selects 0 to 3. When the timer is not running, prewarn_o is low.
- R7: The step that takes the count to 0 (a reload of 0 expires on the first step) raises rst_req_o for exactly one cycle. It also clears the running bit. The count then stays 0 and the configuration stays unchanged until the next applied write.
- R8: An applied write with enable clear stops the timer. The count freezes at its value from before that write, and no reset request follows.
- R9: An applied write with enable set while the timer is running reloads the count from the new reload value at once and restarts the divider period.
- R10: Writes to the status address change neither the control word nor the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| prewarn_o | output | 1 | Pre-warning level |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The count-down is driven with random reload values under divider 1 and divider 64, and sampled at random distances from the load. This separates an off-by-one step position from a correct one, and a sticky or early expiry from a correct one. Directed cases sample the count one cycle either side of a 4096-cycle boundary, and keep a 262144 divide from changing the count for 5000 cycles. These cases separate all four divider ratios. The handshake is tried with a wrong first key, a wrong second key, a lone second key, and an intervening read or status write. Each of these tells a strict adjacency check apart from a lax one. Thresholds are probed one count either side of the crossing for the extreme selects. Stop, restart mid-run and a reload of zero cover the remaining transitions.

// File: rtl/pwd_wdt_pkg.sv
// Shared types and field layout for the password-protected watchdog.
// Assumes a fixed 32-bit control word whose field positions software relies on.
package pwd_wdt_pkg;

    localparam int CNT_W    = 16;
    localparam int EN_BIT   = 31;
    localparam int PWS_LO   = 26;
    localparam int DIVS_LO  = 24;
    localparam int KEY_LO   = 16;

    typedef enum logic {
        UL_LOCKED = 1'b0,
        UL_ARMED  = 1'b1
    } unlock_e;

    typedef struct packed {
        logic             en;
        logic [1:0]       pw_sel;
        logic [1:0]       div_sel;
        logic [CNT_W-1:0] reload;
    } wdt_cfg_t;

    // Pull the configuration fields out of a control write.
    function automatic wdt_cfg_t cfg_from_word(input logic [31:0] w);
        wdt_cfg_t c;
        c.en      = w[EN_BIT];
        c.pw_sel  = w[PWS_LO+1:PWS_LO];
        c.div_sel = w[DIVS_LO+1:DIVS_LO];
        c.reload  = w[CNT_W-1:0];
        return c;
    endfunction

    // Build the control readback with the key field as zero.
    function automatic logic [31:0] word_from_cfg(input wdt_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[EN_BIT]             = c.en;
        w[PWS_LO+1:PWS_LO]    = c.pw_sel;
        w[DIVS_LO+1:DIVS_LO]  = c.div_sel;
        w[CNT_W-1:0]          = c.reload;
        return w;
    endfunction

endpackage

// File: rtl/wdt_unlock.sv
// Two-write unlock sequencer. It produces a one-cycle commit when a control
// write with KEY2 follows straight after a control write with KEY1.
// Assumes at most one bus access per cycle; idle cycles keep the armed state.
module wdt_unlock #(
    parameter logic [7:0] KEY1 = 8'hBE,
    parameter logic [7:0] KEY2 = 8'hDC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       hit_ctrl,
    input  logic [7:0] key,
    output logic       commit
);
    import pwd_wdt_pkg::*;

    unlock_e state_q;

    // A commit needs the armed state and a keyed control write.
    assign commit = (state_q == UL_ARMED) && wr_en && !rd_en && hit_ctrl && (key == KEY2);

    // Arm on the first key; any access while armed returns to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_LOCKED;
        end else begin
            case (state_q)
                UL_LOCKED: if (wr_en && !rd_en && hit_ctrl && key == KEY1) state_q <= UL_ARMED;
                default:   if (wr_en || rd_en) state_q <= UL_LOCKED;
            endcase
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
// Clock prescaler. It emits one tick per 2**shift cycles, with the shift
// picked by a 2-bit select. Assumes SH3 is the largest shift and at least 1.
module wdt_prescaler #(
    parameter int SH1 = 6,
    parameter int SH2 = 12,
    parameter int SH3 = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PRE_W = SH3;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // Terminal count for the selected ratio.
    always_comb begin
        case (sel)
            2'd0:    lim = '0;
            2'd1:    lim = PRE_W'((64'd1 << SH1) - 64'd1);
            2'd2:    lim = PRE_W'((64'd1 << SH2) - 64'd1);
            default: lim = PRE_W'((64'd1 << SH3) - 64'd1);
        endcase
    end

    assign tick = run && !clear && (pre_q == lim);

    // Count cycles while running; restart on clear or on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run || tick) pre_q <= '0;
        else                                  pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/wdt_counter.sv
// Watchdog down-counter. It loads on commit, steps on each tick, and flags
// expiry for one cycle when the count reaches zero, then halts.
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    // Load, stop, step or expire the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                running <= load_en;
                if (load_en) count <= load_val;
            end else if (running && tick) begin
                if (count <= CNT_W'(1)) begin
                    count   <= '0;
                    running <= 1'b0;
                    expire  <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwd_watchdog.sv
// Password-protected watchdog top. It holds the register port, the key
// sequencer, the prescaler, the down-counter and the pre-warning compare.
// Assumes one access per cycle and combinational read data.
module pwd_watchdog #(
    parameter int          ADDR_W    = 4,
    parameter logic [7:0]  KEY1      = 8'hBE,
    parameter logic [7:0]  KEY2      = 8'hDC,
    parameter int          CTRL_ADDR = 0,
    parameter int          STAT_ADDR = 8,
    parameter int          DIV_SH1   = 6,
    parameter int          DIV_SH2   = 12,
    parameter int          DIV_SH3   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              prewarn_o,
    output logic              rst_req_o
);
    import pwd_wdt_pkg::*;

    localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(1) << (CNT_W - 1);

    logic             hit_ctrl;
    logic             hit_stat;
    logic             commit;
    logic             tick;
    wdt_cfg_t         cfg_q;
    wdt_cfg_t         cfg_d;
    logic [CNT_W-1:0] count_q;
    logic             running_q;
    logic             expire_q;
    logic [CNT_W-1:0] warn_thr;
    logic [31:0]      ctrl_rd;
    logic [31:0]      stat_rd;

    assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
    assign hit_stat = (bus_addr == ADDR_W'(STAT_ADDR));
    assign cfg_d    = cfg_from_word(bus_wdata);

    wdt_unlock #(.KEY1(KEY1), .KEY2(KEY2)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .hit_ctrl (hit_ctrl),
        .key      (bus_wdata[KEY_LO+7:KEY_LO]),
        .commit   (commit)
    );

    // Store the configuration on an accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (commit) cfg_q <= cfg_d;
    end

    wdt_prescaler #(.SH1(DIV_SH1), .SH2(DIV_SH2), .SH3(DIV_SH3)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running_q),
        .clear (commit),
        .sel   (cfg_q.div_sel),
        .tick  (tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .load_en  (cfg_d.en),
        .load_val (cfg_d.reload),
        .tick     (tick),
        .count    (count_q),
        .running  (running_q),
        .expire   (expire_q)
    );

    // Pre-warning level: running and at or below the selected fraction.
    always_comb begin
        warn_thr  = TOP_BIT >> cfg_q.pw_sel;
        prewarn_o = running_q && (count_q <= warn_thr);
    end

    assign rst_req_o = expire_q;

    // Read mux for the two registers; other addresses read zero.
    always_comb begin
        ctrl_rd = word_from_cfg(cfg_q);
        stat_rd = '0;
        stat_rd[EN_BIT]    = running_q;
        stat_rd[CNT_W-1:0] = count_q;
        if (hit_ctrl)      bus_rdata = ctrl_rd;
        else if (hit_stat) bus_rdata = stat_rd;
        else               bus_rdata = '0;
    end

endmodule

// File: rtl/pwd_watchdog_chk.sv
// Assertion checker for pwd_watchdog, bound to every instance of the top.
module pwd_watchdog_chk #(
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 8,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              commit,
    input  logic              running,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    input  logic              prewarn,
    input  logic [31:0]       ctrl_rd
);
    // R7: the reset request lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R7: on expiry the count is zero and the timer has halted
    a_r7_halt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (count == '0 && !running));

    // R5: without a commit the running count holds or drops by one
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !$past(commit)) |->
        (count == $past(count) || count == $past(count) - 1'b1));

    // R6: no pre-warning while halted
    a_r6_warn_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        prewarn |-> running);

    // R9: a start or restart leaves the count equal to the stored reload
    a_r9_load_matches: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(commit) && running) |-> (count == ctrl_rd[CNT_W-1:0]));

    // R10: a status write leaves the control word unchanged
    a_r10_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(STAT_ADDR)) |=> $stable(ctrl_rd));

endmodule

bind pwd_watchdog pwd_watchdog_chk #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .CNT_W     (pwd_wdt_pkg::CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .commit   (commit),
    .running  (running_q),
    .count    (count_q),
    .expire   (expire_q),
    .prewarn  (prewarn_o),
    .ctrl_rd  (ctrl_rd)
);

// File: tb/pwd_watchdog_tb.sv
// Self-checking bench for pwd_watchdog: directed corners plus seeded random runs.
module pwd_watchdog_tb;

    localparam int ADDR_W = 4;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              prewarn_o;
    logic              rst_req_o;

    int n_vec = 0;
    int n_bad = 0;
    logic last_pw;

    always #4 clk = ~clk;

    pwd_watchdog u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .prewarn_o (prewarn_o),
        .rst_req_o (rst_req_o)
    );

    function automatic logic [31:0] cw(input logic en, input logic [1:0] pws,
                                       input logic [1:0] dv, input logic [7:0] key,
                                       input logic [15:0] rl);
        return {en, 3'b000, pws, dv, key, rl};
    endfunction

    function automatic logic [31:0] sw(input logic run, input logic [15:0] c);
        return {run, 15'd0, c};
    endfunction

    function automatic int div_of(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 64 : (sel == 2) ? 4096 : 262144;
    endfunction

    // expected count k cycles after a load of rl with divider d
    function automatic int exp_cnt(input int rl, input int d, input int k);
        int eff;
        eff = (rl == 0) ? 1 : rl;
        return (k / d >= eff) ? 0 : rl - k / d;
    endfunction

    function automatic logic exp_run(input int rl, input int d, input int k);
        int eff;
        eff = (rl == 0) ? 1 : rl;
        return (k / d) < eff;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        last_pw = prewarn_o;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic prog(input logic en, input logic [1:0] pws, input logic [1:0] dv,
                        input logic [15:0] rl);
        wr(A_CTRL, cw(1'b0, 2'd0, 2'd0, 8'hBE, 16'd0));
        wr(A_CTRL, cw(en, pws, dv, 8'hDC, rl));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
        rd(A_STAT, d); check("R1 stat", d, 32'h0);
        check("R1 prewarn", {31'd0, prewarn_o}, 32'h0);
        check("R1 rst_req", {31'd0, rst_req_o}, 32'h0);

        // R3 wrong second key
        wr(A_CTRL, cw(1, 0, 0, 8'hBE, 16'd9));
        wr(A_CTRL, cw(1, 0, 0, 8'h11, 16'd9));
        rd(A_CTRL, d); check("R3 bad key2", d, 32'h0);
        // R3 lone second key after failure
        wr(A_CTRL, cw(1, 0, 0, 8'hDC, 16'd9));
        rd(A_CTRL, d); check("R3 lone key2", d, 32'h0);
        // R3 wrong first key
        wr(A_CTRL, cw(1, 0, 0, 8'h12, 16'd9));
        wr(A_CTRL, cw(1, 0, 0, 8'hDC, 16'd9));
        rd(A_CTRL, d); check("R3 bad key1", d, 32'h0);
        // R3 intervening read
        wr(A_CTRL, cw(1, 0, 0, 8'hBE, 16'd9));
        rd(A_STAT, d);
        wr(A_CTRL, cw(1, 0, 0, 8'hDC, 16'd9));
        rd(A_CTRL, d); check("R3 read between", d, 32'h0);
        // R3 / R10 intervening status write
        wr(A_CTRL, cw(1, 0, 0, 8'hBE, 16'd9));
        wr(A_STAT, cw(1, 0, 0, 8'hDC, 16'd9));
        wr(A_CTRL, cw(1, 0, 0, 8'hDC, 16'd9));
        rd(A_STAT, d); check("R3 status write between", d, 32'h0);

        // R2 accepted write, key reads zero; idle cycle between writes allowed
        wr(A_CTRL, cw(0, 0, 0, 8'hBE, 16'd0));
        @(negedge clk);
        wr(A_CTRL, cw(0, 2'd2, 2'd1, 8'hDC, 16'h1234));
        rd(A_CTRL, d); check("R2 readback", d, cw(0, 2'd2, 2'd1, 8'h00, 16'h1234));

        // R4 / R7 start, count-down and single-cycle expiry
        prog(1, 0, 0, 16'd5);
        rd(A_STAT, d); check("R4 load", d, sw(1, 16'd5));
        // now after edge 1
        for (int k = 2; k <= 8; k++) begin
            @(negedge clk);
            check($sformatf("R7 rst_req k=%0d", k), {31'd0, rst_req_o}, {31'd0, k == 5});
        end
        rd(A_STAT, d); check("R7 halted", d, sw(0, 16'd0));
        rd(A_CTRL, d); check("R7 cfg kept", d, cw(1, 0, 0, 8'h00, 16'd5));

        // R7 reload zero expires on first step
        prog(1, 0, 0, 16'd0);
        check("R7 zero no early pulse", {31'd0, rst_req_o}, 32'h0);
        @(negedge clk);
        check("R7 zero pulse", {31'd0, rst_req_o}, 32'h1);

        // R6 thresholds, select 3 and select 0
        prog(1, 2'd3, 0, 16'd4098);
        rd(A_STAT, d); check("R6 s3 4098 count", d, sw(1, 16'd4098));
        check("R6 s3 4098", {31'd0, last_pw}, 32'h0);
        rd(A_STAT, d); check("R6 s3 4097", {31'd0, last_pw}, 32'h0);
        rd(A_STAT, d); check("R6 s3 4096", {31'd0, last_pw}, 32'h1);
        prog(1, 2'd0, 0, 16'd32769);
        rd(A_STAT, d); check("R6 s0 32769", {31'd0, last_pw}, 32'h0);
        rd(A_STAT, d); check("R6 s0 32768", {31'd0, last_pw}, 32'h1);

        // R8 stop freezes the count
        prog(1, 0, 0, 16'd100);
        prog(0, 0, 0, 16'd77);
        repeat (10) @(negedge clk);
        rd(A_STAT, d); check("R8 frozen", d, sw(0, 16'd99));
        check("R8 prewarn low", {31'd0, last_pw}, 32'h0);
        check("R8 no request", {31'd0, rst_req_o}, 32'h0);

        // R9 restart while running
        prog(1, 0, 0, 16'd50);
        repeat (10) @(negedge clk);
        prog(1, 0, 0, 16'd30);
        rd(A_STAT, d); check("R9 reload", d, sw(1, 16'd30));
        repeat (4) @(negedge clk);
        rd(A_STAT, d); check("R9 after 5", d, sw(1, 16'd25));
        prog(1, 0, 2'd1, 16'd3);
        repeat (40) @(negedge clk);
        prog(1, 0, 2'd1, 16'd3);
        repeat (63) @(negedge clk);
        rd(A_STAT, d); check("R9 R5 div64 63", d, sw(1, 16'd3));
        rd(A_STAT, d); check("R9 R5 div64 64", d, sw(1, 16'd2));

        // R10 status write while running changes nothing
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_CTRL, d); check("R10 ctrl", d, cw(1, 0, 2'd1, 8'h00, 16'd3));

        // R5 divider 4096 boundary
        prog(1, 0, 2'd2, 16'd2);
        repeat (4095) @(negedge clk);
        rd(A_STAT, d); check("R5 div4096 4095", d, sw(1, 16'd2));
        rd(A_STAT, d); check("R5 div4096 4096", d, sw(1, 16'd1));
        // R5 divider 262144 holds past 4096
        prog(1, 0, 2'd3, 16'd5);
        repeat (5000) @(negedge clk);
        rd(A_STAT, d); check("R5 div262144", d, sw(1, 16'd5));

        // R4 / R5 / R6 random reloads and sample points
        for (int it = 0; it < 30; it++) begin
            int dsel, dv, rl, k, eff, ec;
            logic er;
            logic [1:0] pws;
            dsel = $urandom_range(1, 0);
            dv   = div_of(dsel);
            rl   = (dsel == 0) ? $urandom_range(200, 0) : $urandom_range(40, 0);
            pws  = 2'($urandom_range(3, 0));
            eff  = (rl == 0) ? 1 : rl;
            k    = $urandom_range(eff * dv + 3, 0);
            prog(1, pws, 2'(dsel), 16'(rl));
            repeat (k) @(negedge clk);
            rd(A_STAT, d);
            ec = exp_cnt(rl, dv, k);
            er = exp_run(rl, dv, k);
            check($sformatf("R5 random rl=%0d d=%0d k=%0d", rl, dv, k), d, sw(er, 16'(ec)));
            check("R6 random prewarn", {31'd0, last_pw},
                  {31'd0, er && (ec <= (32768 >> pws))});
            prog(0, 0, 0, 16'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule